// File: doc/BRIEF.md
# Burst-Access SPI Register Slave

This block lets an SPI host read and write a bank of 8-bit registers that sit on the system clock side. A transaction begins when chip select goes low. The first byte is a header. Its most significant bit gives the direction, and its low seven bits give the address where access starts. Every byte after the header is a data byte. Each data byte goes to, or comes from, the current address, and the address then moves up by one. A host can therefore stream through neighbouring registers without sending the address again, for as long as chip select stays low.

All SPI pins are oversampled in the system clock domain. Each pin passes through a two-flop synchroniser, and the clock edges are detected after that. The bus uses SPI mode 0. The host samples MISO on the rising SCLK edge, and the slave moves MISO on the falling edge. The host may run SCLK at up to 10 MHz, and the system clock must be fast enough to oversample it.

The register bank is outside this block. The block reaches it through a simple port that has a write strobe and a read strobe. Read data is returned one system clock after the read strobe. MISO appears as a data pin plus an output enable, so a pad cell at the chip level can tri-state it.

Top module: `spi_burst_regs`

## Requirements
- R1: The first byte after chip select falls is the header, sent MSB first. Bit 7 set to 1 selects a write and 0 selects a read. Bits 6:0 are the start address. A transaction never mixes read strobes with write strobes.
- R2: In a write transaction, each complete data byte (MSB first) makes exactly one single-cycle `reg_wr` pulse. The pulse carries that byte on `reg_wdata` and the current address on `reg_addr`, and the address then goes up by one.
- R3: In a read transaction, the data bytes return the registers at the start address and the addresses after it, in order, MSB first. Each byte's MSB is on MISO before the first rising SCLK edge of that byte, and later bits change only after falling edges.
- R4: The address wraps from 127 to 0 within a burst, for both reads and writes.
- R5: When chip select rises, the transaction ends. The first byte of the next chip select assertion is always taken as a new header.
- R6: If chip select rises while a byte is incomplete, that byte is thrown away and causes no register write.
- R7: `spi_miso_oe` is 0 while chip select is high. It is also 0 from the moment a header flag bit of 1 is sampled until chip select rises. It is 1 during the data bytes of a read transaction.
- R8: After reset, and before any transaction, `reg_wr`, `reg_rd` and `spi_miso_oe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock from the host |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Drive enable for the MISO pad |
| reg_addr | output | 7 | Register address for the current access |
| reg_wr | output | 1 | Register write strobe, one cycle |
| reg_wdata | output | 8 | Register write data |
| reg_rd | output | 1 | Register read strobe, one cycle |
| reg_rdata | input | 8 | Register read data, valid one cycle after `reg_rd` |

## Verification
A bit counter that is off by one shows up in the first read byte as data shifted by one bit. In a write it shows up as a register getting the wrong value, which the next read-back exposes. A fault in address advance or wrapping puts data in a neighbouring register, and the address checks on the strobes catch this on the second strobe of a burst. State that is not cleared when chip select rises shows up on the next transaction as a misread header, or as a stray write from a partial byte.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  typedef enum logic {
    PH_HEADER = 1'b0,
    PH_DATA   = 1'b1
  } phase_t;
endpackage

// File: rtl/spi_bit_sync.sv
module spi_bit_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/spi_pin_front.sv
module spi_pin_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic mosi_s
);
  localparam int         NPINS   = 3;
  localparam logic [2:0] PIN_RST = 3'b010;

  logic [NPINS-1:0] raw;
  logic [NPINS-1:0] synced;
  logic             sclk_prev_q;

  assign raw = {mosi, cs_n, sclk};

  for (genvar g = 0; g < NPINS; g++) begin : g_sync
    spi_bit_sync #(.STAGES(STAGES), .RST_VAL(PIN_RST[g])) i_sync (
      .clk(clk), .rst_n(rst_n), .d(raw[g]), .q(synced[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev_q <= 1'b0;
    else        sclk_prev_q <= synced[0];
  end

  assign sclk_rise = synced[0] & ~sclk_prev_q;
  assign sclk_fall = ~synced[0] & sclk_prev_q;
  assign cs_act    = ~synced[1];
  assign mosi_s    = synced[2];
endmodule

// File: rtl/spi_burst_seq.sv
module spi_burst_seq
  import spi_burst_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              cs_act,
  input  logic              mosi_s,
  output logic              miso,
  output logic              miso_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_wr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int                BIT_W    = $clog2(DATA_W);
  localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(DATA_W - 1);

  phase_t              phase_q, phase_d;
  logic                dir_wr_q, dir_wr_d;
  logic                wflag_q, wflag_d;
  logic [BIT_W-1:0]    bit_q, bit_d;
  logic [DATA_W-1:0]   sh_in_q, sh_in_d;
  logic [DATA_W-1:0]   sh_out_q, sh_out_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [ADDR_W-1:0]   acc_addr_q, acc_addr_d;
  logic [DATA_W-1:0]   wdata_q, wdata_d;
  logic                wr_q, wr_d;
  logic                rd_q, rd_d;
  logic                load_q;
  logic [DATA_W-1:0]   byte_full;
  logic [ADDR_W-1:0]   addr_inc;

  assign byte_full = {sh_in_q[DATA_W-2:0], mosi_s};
  assign addr_inc  = addr_q + 1'b1;

  always_comb begin
    phase_d    = phase_q;
    dir_wr_d   = dir_wr_q;
    wflag_d    = wflag_q;
    bit_d      = bit_q;
    sh_in_d    = sh_in_q;
    sh_out_d   = sh_out_q;
    addr_d     = addr_q;
    acc_addr_d = acc_addr_q;
    wdata_d    = wdata_q;
    wr_d       = 1'b0;
    rd_d       = 1'b0;
    if (!cs_act) begin
      phase_d  = PH_HEADER;
      wflag_d  = 1'b0;
      bit_d    = '0;
      sh_out_d = '0;
    end else begin
      if (sclk_rise) begin
        sh_in_d = byte_full;
        bit_d   = (bit_q == LAST_BIT) ? '0 : bit_q + 1'b1;
        if (phase_q == PH_HEADER && bit_q == '0 && mosi_s) wflag_d = 1'b1;
        if (bit_q == LAST_BIT) begin
          if (phase_q == PH_HEADER) begin
            phase_d    = PH_DATA;
            dir_wr_d   = byte_full[DATA_W-1];
            addr_d     = byte_full[ADDR_W-1:0];
            acc_addr_d = byte_full[ADDR_W-1:0];
            rd_d       = ~byte_full[DATA_W-1];
          end else if (dir_wr_q) begin
            wr_d       = 1'b1;
            wdata_d    = byte_full;
            acc_addr_d = addr_q;
            addr_d     = addr_inc;
          end else begin
            rd_d       = 1'b1;
            acc_addr_d = addr_inc;
            addr_d     = addr_inc;
          end
        end
      end else if (sclk_fall && bit_q != '0) begin
        sh_out_d = {sh_out_q[DATA_W-2:0], 1'b0};
      end
      if (load_q) sh_out_d = reg_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_HEADER;
      dir_wr_q   <= 1'b0;
      wflag_q    <= 1'b0;
      bit_q      <= '0;
      sh_in_q    <= '0;
      sh_out_q   <= '0;
      addr_q     <= '0;
      acc_addr_q <= '0;
      wdata_q    <= '0;
      wr_q       <= 1'b0;
      rd_q       <= 1'b0;
      load_q     <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      dir_wr_q   <= dir_wr_d;
      wflag_q    <= wflag_d;
      bit_q      <= bit_d;
      sh_in_q    <= sh_in_d;
      sh_out_q   <= sh_out_d;
      addr_q     <= addr_d;
      acc_addr_q <= acc_addr_d;
      wdata_q    <= wdata_d;
      wr_q       <= wr_d;
      rd_q       <= rd_d;
      load_q     <= rd_q;
    end
  end

  assign miso_oe   = cs_act & ~wflag_q;
  assign miso      = miso_oe & sh_out_q[DATA_W-1];
  assign reg_addr  = acc_addr_q;
  assign reg_wr    = wr_q;
  assign reg_wdata = wdata_q;
  assign reg_rd    = rd_q;
endmodule

// File: rtl/spi_burst_regs.sv
module spi_burst_regs #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_wr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata
);
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  logic       sclk_rise, sclk_fall, cs_act, mosi_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  spi_pin_front #(.STAGES(SYNC_STAGES)) i_front (
    .clk(clk), .rst_n(rst_int_n),
    .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_act(cs_act), .mosi_s(mosi_s)
  );

  spi_burst_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_seq (
    .clk(clk), .rst_n(rst_int_n),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_act(cs_act), .mosi_s(mosi_s),
    .miso(spi_miso), .miso_oe(spi_miso_oe),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );
endmodule

// File: rtl/spi_burst_regs_chk.sv
module spi_burst_regs_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_cs_n,
  input logic              spi_miso_oe,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic              reg_rd
);
  logic [2:0]        cs_hist_q;
  logic              seen_wr_q, seen_rd_q;
  logic [ADDR_W-1:0] last_q;
  logic [ADDR_W-1:0] last_inc;
  logic              cs_idle;

  assign last_inc = last_q + 1'b1;
  assign cs_idle  = spi_cs_n & (&cs_hist_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_hist_q <= 3'b111;
      seen_wr_q <= 1'b0;
      seen_rd_q <= 1'b0;
      last_q    <= '0;
    end else begin
      cs_hist_q <= {cs_hist_q[1:0], spi_cs_n};
      if (reg_wr || reg_rd) last_q <= reg_addr;
      if (reg_wr)       seen_wr_q <= 1'b1;
      else if (cs_idle) seen_wr_q <= 1'b0;
      if (reg_rd)       seen_rd_q <= 1'b1;
      else if (cs_idle) seen_rd_q <= 1'b0;
    end
  end

  // R7
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |-> !spi_miso_oe);

  // R2
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  // R4
  wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && seen_wr_q) |-> (reg_addr == last_inc));

  // R3
  rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && seen_rd_q) |-> (reg_addr == last_inc));

  // R1
  dir_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_wr_q |-> !reg_rd) and (seen_rd_q |-> !reg_wr));
endmodule

bind spi_burst_regs spi_burst_regs_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso_oe(spi_miso_oe),
  .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd)
);

// File: tb/test_spi_burst_regs.sv
`timescale 1ns/1ps
module test_spi_burst_regs;
  logic       clk, rst_n;
  logic       sclk, cs_n, mosi;
  logic       miso, miso_oe;
  logic [6:0] reg_addr;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;

  logic [7:0] bank  [128];
  logic [7:0] model [128];
  logic [7:0] tx_buf [16];
  int         n_chk, n_err;
  bit         done;

  spi_burst_regs i_spi_burst_regs (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (reg_wr) bank[reg_addr] <= reg_wdata;
    if (reg_rd) reg_rdata <= bank[reg_addr];
  end

  function automatic logic [7:0] seed_val(int i);
    return 8'((i * 37 + 5) ^ (i >> 2));
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = tx[i];
      #50 sclk = 1'b1;
      rx[i] = miso;
      #50 sclk = 1'b0;
    end
  endtask

  task automatic cs_begin();
    cs_n = 1'b0;
    #100;
  endtask

  task automatic cs_end();
    #50 cs_n = 1'b1;
    #250;
  endtask

  task automatic burst_write(input logic [6:0] a, input int n, string req);
    logic [7:0] rx;
    cs_begin();
    spi_byte({1'b1, a}, 8, rx);
    #20 chk({req, " R7 oe after write flag"}, int'(miso_oe), 0);
    for (int k = 0; k < n; k++) begin
      spi_byte(tx_buf[k], 8, rx);
      model[7'(a + k)] = tx_buf[k];
    end
    cs_end();
  endtask

  task automatic burst_read(input logic [6:0] a, input int n, string req);
    logic [7:0] rx;
    cs_begin();
    spi_byte({1'b0, a}, 8, rx);
    #20 chk({req, " R7 oe in read"}, int'(miso_oe), 1);
    for (int k = 0; k < n; k++) begin
      spi_byte(8'h00, 8, rx);
      chk({req, " R3 read data"}, int'(rx), int'(model[7'(a + k)]));
    end
    cs_end();
  endtask

  initial begin
    #1;
    n_chk = 0; n_err = 0; done = 0;
    sclk = 0; cs_n = 1; mosi = 0; rst_n = 0;
    for (int i = 0; i < 128; i++) begin
      bank[i]  = seed_val(i);
      model[i] = seed_val(i);
    end
    void'($urandom(32'h5EED_0042));
    #40 rst_n = 1;
    #100;
    // R8 reset state
    chk("R8 reg_wr", int'(reg_wr), 0);
    chk("R8 reg_rd", int'(reg_rd), 0);
    chk("R8 miso_oe", int'(miso_oe), 0);

    // R2 plain write burst, R3 read back, R1 header decode
    for (int k = 0; k < 4; k++) tx_buf[k] = 8'hA0 + 8'(k);
    burst_write(7'd5, 4, "R2");
    burst_read(7'd4, 6, "R1");

    // R4 wrap through 127 -> 0
    tx_buf[0] = 8'h11; tx_buf[1] = 8'h22; tx_buf[2] = 8'h33; tx_buf[3] = 8'h44;
    burst_write(7'd126, 4, "R4");
    burst_read(7'd125, 5, "R4");

    // R6 partial byte discarded
    begin
      logic [7:0] rx;
      cs_begin();
      spi_byte({1'b1, 7'd40}, 8, rx);
      spi_byte(8'h5A, 8, rx);
      model[40] = 8'h5A;
      spi_byte(8'hC3, 4, rx);
      cs_end();
      chk("R6 partial no write", int'(bank[41]), int'(model[41]));
      burst_read(7'd40, 2, "R6");
    end

    // R5 new header after CS rise
    tx_buf[0] = 8'h77;
    burst_write(7'd60, 1, "R5");
    tx_buf[0] = 8'h88;
    burst_write(7'd90, 1, "R5");
    chk("R5 second header addr", int'(bank[90]), 8'h88);
    chk("R5 no spill to next addr", int'(bank[61]), int'(model[61]));
    chk("R7 oe idle", int'(miso_oe), 0);

    // random bursts
    for (int t = 0; t < 30; t++) begin
      logic [6:0] a;
      int n;
      a = 7'($urandom_range(0, 127));
      n = $urandom_range(1, 6);
      if ($urandom_range(0, 1) == 1) begin
        for (int k = 0; k < n; k++) tx_buf[k] = 8'($urandom);
        burst_write(a, n, "R2");
      end else begin
        burst_read(a, n, "R3");
      end
    end
    for (int i = 0; i < 128; i++) chk("R2 bank contents", int'(bank[i]), int'(model[i]));

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule